// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits between an execution unit and a load/store memory port. On that port a request is not finished when it is issued: the responder keeps a busy line high until the operation has really completed. The requester takes one command at a time from upstream. A command is a load or a store, an address, a byte length and store data. The requester raises exactly one of the two request lines. It presents the address together with an address-valid flag and holds both steady until the responder lets busy fall. This means the responder never needs its own copy of the address.

After the request is raised, the responder answers with a one-cycle address acknowledge or a one-cycle fault pulse. A fault ends the operation at once.

- **Store:** the requester drives a one-cycle store-valid pulse with the data in the cycle after the acknowledge. It then waits for busy to drop.
- **Load:** the requester captures the returned data in the one cycle the responder marks it valid.

Every completed operation returns upstream through registered outputs with a one-cycle done pulse. A synchronous abort input cancels an operation in flight and signals the cancellation to the responder.

Top module: `ldst_port_requester`

## Requirements
- R1: `cmd_ready_o` is high only when the requester is idle and `port_busy_i` is low. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high, and at no other edge.
- R2: In the cycle after a command is taken, exactly one request line is high: `port_st_req_o` if `cmd_is_store_i` was 1, `port_ld_req_o` if it was 0. In that same cycle `port_addr_valid_o` is high, `port_addr_o` equals the accepted address and `port_len_o` equals the accepted length.
- R3: The request line, `port_addr_valid_o` and `port_addr_o` stay unchanged for the whole operation. They drop in the cycle after the operation ends.
- R4: A `port_fault_i` pulse while the address is awaiting acknowledge ends the operation. In the next cycle `done_o` is 1, `done_fault_o` is 1 and `done_rdata_o` is 0.
- R5: For a store, `port_st_valid_o` is high for exactly one cycle, namely the cycle after `port_addr_ack_i`, with `port_st_data_o` equal to the accepted data. It is never high before the acknowledge.
- R6: After the store-valid cycle, the requester waits for `port_busy_i` to be low. In the cycle after that, `done_o` is 1, `done_fault_o` is 0 and `done_rdata_o` is 0.
- R7: For a load, `port_ld_data_i` is captured on the cycle `port_ld_valid_i` is high. This may be the acknowledge cycle or any later one. In the next cycle `done_o` is 1, `done_rdata_o` holds the captured data and `done_fault_o` is 0.
- R8: `done_o` lasts one cycle. `done_rdata_o` and `done_fault_o` keep their values until the next `done_o`.
- R9: `abort_i` during an operation drives `port_kill_o` high in that same cycle. The next cycle is idle, with all port request lines low and no `done_o` pulse. `abort_i` while idle leaves `port_kill_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Upstream command present |
| cmd_ready_o | output | 1 | Requester can take a command |
| cmd_is_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W (48) | Command address |
| cmd_len_i | input | LEN_W (4) | Byte length |
| cmd_wdata_i | input | DATA_W (64) | Store data |
| abort_i | input | 1 | Synchronous cancel of the operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| done_fault_o | output | 1 | Completed operation faulted |
| done_rdata_o | output | DATA_W (64) | Load result, 0 for stores and faults |
| port_ld_req_o | output | 1 | Load request to responder |
| port_st_req_o | output | 1 | Store request to responder |
| port_len_o | output | LEN_W (4) | Byte length to responder |
| port_addr_valid_o | output | 1 | Address valid |
| port_addr_o | output | ADDR_W (48) | Held address |
| port_kill_o | output | 1 | Cancel indication to responder |
| port_busy_i | input | 1 | Responder busy |
| port_addr_ack_i | input | 1 | One-cycle address acknowledge |
| port_fault_i | input | 1 | One-cycle fault pulse |
| port_ld_valid_i | input | 1 | Load data valid, one cycle |
| port_ld_data_i | input | DATA_W (64) | Load data |
| port_st_valid_o | output | 1 | Store data valid, one cycle |
| port_st_data_o | output | DATA_W (64) | Store data |

## Verification
Request lines and the held address appear one edge after acceptance. The store-valid pulse appears one edge after the acknowledge. The done pulse and its data appear one edge after the ending event: a fault, load-valid, or busy low while draining a store. `cmd_ready_o` and `port_kill_o` are combinational in the present cycle. The bench drives every input at the falling edge and samples outputs 1 ns later. Each check therefore sees exactly the rising edges counted for that result. Random latencies place the acknowledge and load-valid at 0 to 3 cycles of delay, so the held-address and single-pulse rules are exercised at every such distance.

// File: rtl/ldst_req_pkg.sv
package ldst_req_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_ADDR    = 3'd1,
    S_LDWAIT  = 3'd2,
    S_STSEND  = 3'd3,
    S_STDRAIN = 3'd4
  } req_state_e;

  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_LOAD  = 2'd1,
    END_STORE = 2'd2,
    END_FAULT = 2'd3
  } end_kind_e;

  // Which kind of completion (if any) happens in this cycle.
  function automatic end_kind_e classify_end(req_state_e s, logic is_store,
                                             logic ack, logic fault,
                                             logic ldv, logic busy);
    end_kind_e k;
    k = END_NONE;
    case (s)
      S_ADDR: begin
        if (fault) k = END_FAULT;
        else if (ack && !is_store && ldv) k = END_LOAD;
      end
      S_LDWAIT:  if (ldv) k = END_LOAD;
      S_STDRAIN: if (!busy) k = END_STORE;
      default:   k = END_NONE;
    endcase
    return k;
  endfunction

  function automatic req_state_e next_state(req_state_e s, logic is_store,
                                            logic start, logic abort,
                                            logic ack, logic fault,
                                            logic ldv, logic busy);
    req_state_e n;
    n = s;
    if (s != S_IDLE && abort) begin
      n = S_IDLE;
    end else begin
      case (s)
        S_IDLE: if (start) n = S_ADDR;
        S_ADDR: begin
          if (fault) n = S_IDLE;
          else if (ack) begin
            if (is_store) n = S_STSEND;
            else if (ldv) n = S_IDLE;
            else n = S_LDWAIT;
          end
        end
        S_LDWAIT:  if (ldv) n = S_IDLE;
        S_STSEND:  n = S_STDRAIN;
        S_STDRAIN: if (!busy) n = S_IDLE;
        default:   n = S_IDLE;
      endcase
    end
    return n;
  endfunction

  // Value returned upstream on completion.
  function automatic logic [63:0] result_word(end_kind_e k, logic [63:0] ld);
    return (k == END_LOAD) ? ld : 64'd0;
  endfunction

endpackage

// File: rtl/ldst_req_fsm.sv
module ldst_req_fsm
  import ldst_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic       is_store_q_i,
  input  logic       abort_i,
  input  logic       port_busy_i,
  input  logic       port_addr_ack_i,
  input  logic       port_fault_i,
  input  logic       port_ld_valid_i,
  output req_state_e state_o,
  output logic       cmd_ready_o,
  output logic       ev_accept_o,
  output logic       ev_abort_o,
  output end_kind_e  ev_end_o
);

  req_state_e state_q, state_d;
  logic       active;

  assign active      = (state_q != S_IDLE);
  assign cmd_ready_o = !active && !port_busy_i;
  assign ev_accept_o = cmd_valid_i && cmd_ready_o;
  assign ev_abort_o  = active && abort_i;
  assign ev_end_o    = ev_abort_o ? END_NONE :
                       classify_end(state_q, is_store_q_i, port_addr_ack_i,
                                    port_fault_i, port_ld_valid_i, port_busy_i);

  always_comb begin
    state_d = next_state(state_q, is_store_q_i, ev_accept_o, abort_i,
                         port_addr_ack_i, port_fault_i, port_ld_valid_i,
                         port_busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_ready_not_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !port_busy_i);

  assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_o |=> (state_q == S_ADDR));

  assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort_o |=> (state_q == S_IDLE));

  assert_store_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_STSEND) |-> $past(port_addr_ack_i));

endmodule

// File: rtl/ldst_req_cmd_hold.sv
module ldst_req_cmd_hold #(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              is_store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              active_i,
  output logic              is_store_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] wdata_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_store_o <= 1'b0;
      addr_o     <= '0;
      len_o      <= '0;
      wdata_o    <= '0;
    end else if (load_i) begin
      is_store_o <= is_store_i;
      addr_o     <= addr_i;
      len_o      <= len_i;
      wdata_o    <= wdata_i;
    end
  end

  // Held command must not move while an operation is in flight.
  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && $past(active_i)) |-> ($stable(addr_o) && $stable(is_store_o)));

endmodule

// File: rtl/ldst_req_capture.sv
module ldst_req_capture
  import ldst_req_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  end_kind_e         ev_end_i,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int WORD_W = 64;
  logic [WORD_W-1:0] ld_wide;
  logic [WORD_W-1:0] res_wide;

  generate
    if (DATA_W >= WORD_W) begin : g_narrow
      assign ld_wide = ld_data_i[WORD_W-1:0];
    end else begin : g_pad
      assign ld_wide = {{(WORD_W-DATA_W){1'b0}}, ld_data_i};
    end
  endgenerate

  assign res_wide = result_word(ev_end_i, ld_wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= (ev_end_i != END_NONE);
      if (ev_end_i != END_NONE) begin
        fault_o <= (ev_end_i == END_FAULT);
        rdata_o <= DATA_W'(res_wide);
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end_i == END_NONE) |=> ($stable(rdata_o) && $stable(fault_o)));

endmodule

// File: rtl/ldst_port_requester.sv
module ldst_port_requester
  import ldst_req_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_is_store_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic              abort_i,
  output logic              done_o,
  output logic              done_fault_o,
  output logic [DATA_W-1:0] done_rdata_o,
  output logic              port_ld_req_o,
  output logic              port_st_req_o,
  output logic [LEN_W-1:0]  port_len_o,
  output logic              port_addr_valid_o,
  output logic [ADDR_W-1:0] port_addr_o,
  output logic              port_kill_o,
  input  logic              port_busy_i,
  input  logic              port_addr_ack_i,
  input  logic              port_fault_i,
  input  logic              port_ld_valid_i,
  input  logic [DATA_W-1:0] port_ld_data_i,
  output logic              port_st_valid_o,
  output logic [DATA_W-1:0] port_st_data_o
);

  req_state_e state;
  logic       ev_accept, ev_abort, is_store_q, active;
  end_kind_e  ev_end;

  ldst_req_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid_i    (cmd_valid_i),
    .is_store_q_i   (is_store_q),
    .abort_i        (abort_i),
    .port_busy_i    (port_busy_i),
    .port_addr_ack_i(port_addr_ack_i),
    .port_fault_i   (port_fault_i),
    .port_ld_valid_i(port_ld_valid_i),
    .state_o        (state),
    .cmd_ready_o    (cmd_ready_o),
    .ev_accept_o    (ev_accept),
    .ev_abort_o     (ev_abort),
    .ev_end_o       (ev_end)
  );

  assign active = (state != S_IDLE);

  ldst_req_cmd_hold #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ev_accept),
    .is_store_i(cmd_is_store_i),
    .addr_i    (cmd_addr_i),
    .len_i     (cmd_len_i),
    .wdata_i   (cmd_wdata_i),
    .active_i  (active),
    .is_store_o(is_store_q),
    .addr_o    (port_addr_o),
    .len_o     (port_len_o),
    .wdata_o   (port_st_data_o)
  );

  ldst_req_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_end_i (ev_end),
    .ld_data_i(port_ld_data_i),
    .done_o   (done_o),
    .fault_o  (done_fault_o),
    .rdata_o  (done_rdata_o)
  );

  assign port_ld_req_o     = active && !is_store_q;
  assign port_st_req_o     = active && is_store_q;
  assign port_addr_valid_o = active;
  assign port_st_valid_o   = (state == S_STSEND);
  assign port_kill_o       = ev_abort;

  assert_one_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_ld_req_o && port_st_req_o));

  assert_st_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_st_valid_o |=> !port_st_valid_o);

  assert_kill_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_kill_o |=> (!port_addr_valid_o && !done_o));

  assert_fault_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_fault_i && state == S_ADDR && !abort_i) |=> (done_o && done_fault_o));

endmodule

// File: tb/ldst_port_requester_tb_top.sv
`timescale 1ns/1ps
module ldst_port_requester_tb_top;

  localparam int AW = 48;
  localparam int LW = 4;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 0, cmd_is_store = 0, abort = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          busy = 0, ack = 0, fault = 0, ldv = 0;
  logic [DW-1:0] ld_data = '0;
  logic          cmd_ready, done, done_fault, ld_req, st_req, addr_valid, kill, st_valid;
  logic [DW-1:0] done_rdata, st_data;
  logic [LW-1:0] plen;
  logic [AW-1:0] paddr;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ldst_port_requester dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_is_store_i(cmd_is_store),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .cmd_wdata_i(cmd_wdata),
    .abort_i(abort), .done_o(done), .done_fault_o(done_fault), .done_rdata_o(done_rdata),
    .port_ld_req_o(ld_req), .port_st_req_o(st_req), .port_len_o(plen),
    .port_addr_valid_o(addr_valid), .port_addr_o(paddr), .port_kill_o(kill),
    .port_busy_i(busy), .port_addr_ack_i(ack), .port_fault_i(fault),
    .port_ld_valid_i(ldv), .port_ld_data_i(ld_data),
    .port_st_valid_o(st_valid), .port_st_data_o(st_data)
  );

  function automatic logic [DW-1:0] exp_result(bit is_st, bit flt, logic [DW-1:0] d);
    if (is_st || flt) return '0;
    return d;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_held(bit is_st, logic [AW-1:0] a);
    chk(addr_valid == 1 && paddr == a, "R3 address held", paddr, a);
    chk(ld_req == !is_st && st_req == is_st, "R3 request held", {ld_req, st_req}, {!is_st, is_st});
    chk(st_valid == 0, "R5 no store-valid before ack", st_valid, 0);
  endtask

  // One full operation with a bench-side responder.
  task automatic run_op(bit is_st, logic [AW-1:0] a, logic [LW-1:0] l,
                        logic [DW-1:0] wd, int ack_dly, bit flt, int ld_dly,
                        logic [DW-1:0] rd);
    logic [DW-1:0] exp;
    step();
    cmd_valid = 1; cmd_is_store = is_st; cmd_addr = a; cmd_len = l; cmd_wdata = wd; busy = 0;
    #1 chk(cmd_ready == 1, "R1 ready when idle", cmd_ready, 1);
    step();
    cmd_valid = 0; cmd_addr = ~a; cmd_wdata = ~wd; busy = 1;
    #1;
    chk(ld_req == !is_st && st_req == is_st, "R2 request line", {ld_req, st_req}, {!is_st, is_st});
    chk(addr_valid == 1 && paddr == a, "R2 address", paddr, a);
    chk(plen == l, "R2 length", plen, l);
    chk(cmd_ready == 0, "R1 not ready while active", cmd_ready, 0);
    for (int k = 0; k < ack_dly; k++) begin
      step(); #1 chk_held(is_st, a);
    end
    step();
    if (flt) begin
      fault = 1; busy = 0;
      step(); fault = 0;
      #1;
      chk(done == 1 && done_fault == 1, "R4 fault done", {done, done_fault}, 2'b11);
      chk(done_rdata == 0, "R4 fault rdata", done_rdata, 0);
      chk(addr_valid == 0, "R3 drop after end", addr_valid, 0);
      exp = 0;
    end else if (is_st) begin
      ack = 1;
      step(); ack = 0;
      #1;
      chk(st_valid == 1, "R5 store-valid after ack", st_valid, 1);
      chk(st_data == wd, "R5 store data", st_data, wd);
      step(); busy = 0;
      #1;
      chk(st_valid == 0, "R5 store-valid one cycle", st_valid, 0);
      chk(st_req == 1 && done == 0, "R6 waiting busy low", {st_req, done}, 2'b10);
      step(); #1;
      exp = exp_result(1, 0, rd);
      chk(done == 1 && done_fault == 0 && done_rdata == exp, "R6 store done", done_rdata, exp);
      chk(addr_valid == 0, "R3 drop after end", addr_valid, 0);
    end else begin
      ack = 1;
      if (ld_dly == 0) begin
        ldv = 1; ld_data = rd; busy = 0;
      end
      for (int k = 1; k <= ld_dly; k++) begin
        step(); ack = 0;
        if (k == ld_dly) begin
          ldv = 1; ld_data = rd; busy = 0;
        end else begin
          #1 chk(done == 0 && ld_req == 1 && paddr == a, "R3 load wait held", paddr, a);
        end
      end
      step(); ack = 0; ldv = 0; ld_data = ~rd;
      #1;
      exp = exp_result(0, 0, rd);
      chk(done == 1 && done_fault == 0 && done_rdata == exp, "R7 load data", done_rdata, exp);
      chk(addr_valid == 0, "R3 drop after end", addr_valid, 0);
    end
    step(); #1;
    chk(done == 0, "R8 done single cycle", done, 0);
    chk(done_rdata == exp && done_fault == flt, "R8 result held", done_rdata, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) step();
    #1;
    chk(done == 0 && addr_valid == 0 && ld_req == 0 && st_req == 0, "R1 reset outputs", done, 0);
    step(); rst_n = 1;
    #1 chk(cmd_ready == 1, "R1 ready after reset", cmd_ready, 1);

    // R1: busy high while idle blocks acceptance
    step(); busy = 1; cmd_valid = 1; cmd_addr = 48'h1234;
    #1 chk(cmd_ready == 0, "R1 busy blocks ready", cmd_ready, 0);
    step(); cmd_valid = 0; busy = 0;
    #1 chk(addr_valid == 0 && ld_req == 0, "R1 no accept while busy", addr_valid, 0);

    // directed corners
    run_op(0, 48'hFFFF_FFFF_FFFF, 4'hF, 64'h0, 0, 0, 0, 64'hDEAD_BEEF_0BAD_F00D);
    run_op(1, 48'h0, 4'h1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 0, 0, 64'h0);
    run_op(0, 48'hA5A5, 4'h8, 64'h0, 2, 1, 0, 64'h55);
    run_op(1, 48'h7777, 4'h4, 64'h1122, 0, 1, 0, 64'h0);
    run_op(0, 48'h4242, 4'h2, 64'h0, 1, 0, 3, 64'hCAFE);

    // R9: abort mid-operation
    step(); abort = 1;
    #1 chk(kill == 0, "R9 kill low when idle", kill, 0);
    step(); abort = 0; cmd_valid = 1; cmd_is_store = 1; cmd_addr = 48'h99;
    step(); cmd_valid = 0; busy = 1;
    step(); abort = 1;
    #1 chk(kill == 1, "R9 kill while active", kill, 1);
    step(); abort = 0; busy = 0;
    #1;
    chk(addr_valid == 0 && st_req == 0 && st_valid == 0, "R9 idle after abort", addr_valid, 0);
    chk(done == 0, "R9 no done on abort", done, 0);
    chk(cmd_ready == 1, "R9 ready after abort", cmd_ready, 1);

    // constrained random
    for (int i = 0; i < 80; i++) begin
      bit is_st = 1'($urandom);
      bit flt   = ($urandom % 6) == 0;
      run_op(is_st, AW'({$urandom, $urandom}), LW'($urandom),
             {$urandom, $urandom}, $urandom % 4, flt, $urandom % 4,
             {$urandom, $urandom});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule